// File: doc/BRIEF.md
# Interrupt moderation controller

This block spaces out the interrupts that one host-controller interrupter raises toward the CPU. Software reaches it through two 32-bit registers on a simple synchronous register bus. The control register holds an enable flag and a pending flag. The pending flag is cleared by writing one to it. The pacing register holds a reload interval and a live down counter.

Each time software clears the pending flag, the counter is loaded from the interval. A tick strobe then counts it down, once per 250 ns step, until it reaches zero, where it stops. The pending flag is raised again only when the counter has run out, the event ring holds work, the handler is idle and interrupts are enabled. The interrupt line is a registered level. Software can also write the counter directly to speed up or delay the next interrupt.

Top module: `irq_pacer`

## Requirements
- R1: After reset the control register (offset 0x0) reads 0x00000000, the pacing register (offset 0x4) reads 0x00000FA0 (interval 4000, counter 0) and `irq_o` is 0.
- R2: In the control register, bit 1 is the enable flag and can be read and written. Bits 31:2 always read 0 and writes to them are ignored. A read of any unmapped offset returns 0. `bus_rdata` shows the addressed register one cycle after `bus_addr` is presented.
- R3: The pending flag (control bit 0) becomes 1 one cycle after a cycle in which all of these hold: enable is 1, the counter is 0, `ring_ne_i` is 1 and `busy_i` is 0. It then stays 1 until software clears it.
- R4: Writing 1 to control bit 0 clears the pending flag, and writing 0 to it has no effect. If a clear and a set condition fall in the same cycle, the clear wins.
- R5: A write that clears the pending flag loads the counter (pacing bits 31:16) with the interval (pacing bits 15:0).
- R6: When the counter is nonzero, each cycle with `tick_i` high lowers it by one. At zero it holds and never wraps.
- R7: A write to the pacing register sets the counter to bits 31:16 of the written data in the next cycle. This takes priority over a tick decrement or a reload in the same cycle.
- R8: A write to the pacing register stores bits 15:0 as the new interval, and it reads back unchanged.
- R9: `irq_o` is 1 in the cycle after one in which the counter is 0, `ring_ne_i` is 1, enable is 1, pending is 1 and `busy_i` is 0. It is 0 in the cycle after any of these fails.
- R10: While enable is 0, `irq_o` stays 0 and the pending flag is never set, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_i | input | 1 | Countdown strobe, one pulse per 250 ns |
| ring_ne_i | input | 1 | Event ring holds at least one event |
| busy_i | input | 1 | Event handler busy |
| irq_o | output | 1 | Interrupt request level |

## Verification
There are two same-cycle collisions. The first is a write-one-to-clear of the pending flag in a cycle where the set condition also holds. The second is a software write of the counter on a cycle with a tick strobe. Directed steps force each one: the counter is left at zero with events waiting while the clear is written, and a pacing-register write is issued with `tick_i` held high. The results are judged by reading back the control and pacing registers, which must show pending at 0 with the counter at the interval, and the written counter value with no decrement. A long seeded random run then mixes writes, ticks and input changes so that both collisions recur, and compares every output each cycle against a cycle model in the bench.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 2 * CNT_W;
  localparam int EN_BIT = 1;
  localparam int PD_BIT = 0;
endpackage

// File: rtl/irq_pacer_ctrl.sv
module irq_pacer_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_bits,
  input  logic       cnt_zero,
  input  logic       ring_ne,
  input  logic       busy,
  output logic       en_q,
  output logic       pend_q,
  output logic       clr_pulse
);
  import irq_pacer_pkg::*;

  logic set_cond;

  assign clr_pulse = ctl_wr && ctl_bits[PD_BIT];
  assign set_cond  = en_q && cnt_zero && ring_ne && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= ctl_bits[EN_BIT];
      if (clr_pulse)     pend_q <= 1'b0;
      else if (set_cond) pend_q <= 1'b1;
    end
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && cnt_zero && ring_ne && !busy && !clr_pulse) |=> pend_q);
  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_pulse |=> !pend_q);
  // R10
  pend_no_set_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/irq_pacer_cnt.sv
module irq_pacer_cnt #(
  parameter int CNT_W        = 16,
  parameter int INTERVAL_RST = 4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mod_wr,
  input  logic [2*CNT_W-1:0] wdata,
  input  logic               reload,
  input  logic               tick,
  output logic [CNT_W-1:0]   interval_q,
  output logic [CNT_W-1:0]   cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      interval_q <= CNT_W'(INTERVAL_RST);
      cnt_q      <= '0;
    end else begin
      if (mod_wr) interval_q <= wdata[CNT_W-1:0];
      if (mod_wr)                     cnt_q <= wdata[2*CNT_W-1:CNT_W];
      else if (reload)                cnt_q <= interval_q;
      else if (tick && cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end
  end

  // R6
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !mod_wr && !reload) |=> cnt_q == '0);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != '0 && !mod_wr && !reload) |=> cnt_q == $past(cnt_q) - ONE);
  // R5
  cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (reload && !mod_wr) |=> cnt_q == $past(interval_q));
  // R7
  cnt_sw_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mod_wr |=> cnt_q == $past(wdata[2*CNT_W-1:CNT_W]));
endmodule

// File: rtl/irq_pacer_qual.sv
module irq_pacer_qual (
  input  logic clk,
  input  logic rst,
  input  logic cnt_zero,
  input  logic ring_ne,
  input  logic en,
  input  logic pend,
  input  logic busy,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cnt_zero && ring_ne && en && pend && !busy;
  end

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_q);
  // R9
  irq_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !irq_q);
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int ADDR_W       = 4,
  parameter int INTERVAL_RST = 4000,
  parameter int CTL_OFS      = 0,
  parameter int MOD_OFS      = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [irq_pacer_pkg::DATA_W-1:0]  bus_wdata,
  output logic [irq_pacer_pkg::DATA_W-1:0]  bus_rdata,
  input  logic                              tick_i,
  input  logic                              ring_ne_i,
  input  logic                              busy_i,
  output logic                              irq_o
);
  import irq_pacer_pkg::*;

  logic             ctl_sel, mod_sel;
  logic             en_q, pend_q, clr_pulse, cnt_zero;
  logic [CNT_W-1:0] interval_q, cnt_q;

  assign ctl_sel  = bus_addr == ADDR_W'(CTL_OFS);
  assign mod_sel  = bus_addr == ADDR_W'(MOD_OFS);
  assign cnt_zero = cnt_q == '0;

  irq_pacer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (bus_we && ctl_sel),
    .ctl_bits  (bus_wdata[1:0]),
    .cnt_zero  (cnt_zero),
    .ring_ne   (ring_ne_i),
    .busy      (busy_i),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .clr_pulse (clr_pulse)
  );

  irq_pacer_cnt #(.CNT_W(CNT_W), .INTERVAL_RST(INTERVAL_RST)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .mod_wr     (bus_we && mod_sel),
    .wdata      (bus_wdata),
    .reload     (clr_pulse),
    .tick       (tick_i),
    .interval_q (interval_q),
    .cnt_q      (cnt_q)
  );

  irq_pacer_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .cnt_zero (cnt_zero),
    .ring_ne  (ring_ne_i),
    .en       (en_q),
    .pend     (pend_q),
    .busy     (busy_i),
    .irq_q    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (ctl_sel) bus_rdata <= {{(DATA_W-2){1'b0}}, en_q, pend_q};
    else if (mod_sel) bus_rdata <= {cnt_q, interval_q};
    else              bus_rdata <= '0;
  end

  // R2
  rd_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_sel |=> bus_rdata[DATA_W-1:2] == '0);
endmodule

// File: tb/tb_irq_pacer.sv
module tb_irq_pacer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_we = 1'b0, tick_i = 1'b0, ring_ne_i = 1'b0, busy_i = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0, errors = 0;

  irq_pacer dut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .ring_ne_i(ring_ne_i), .busy_i(busy_i), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle model built from the requirements
  logic        m_en, m_pd, m_irq;
  logic [15:0] m_ivl, m_cnt;
  logic [31:0] m_rd;
  logic        m_clr;

  function automatic logic [31:0] f_read(input logic [3:0] a, input logic en,
      input logic pd, input logic [15:0] c, input logic [15:0] iv);
    if (a == 4'h0) return {30'd0, en, pd};
    if (a == 4'h4) return {c, iv};
    return 32'd0;
  endfunction

  function automatic logic f_qual(input logic [15:0] c, input logic r,
      input logic en, input logic pd, input logic b);
    return (c == 16'd0) && r && en && pd && !b;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 0; m_pd <= 0; m_irq <= 0; m_ivl <= 16'd4000; m_cnt <= 0; m_rd <= 0;
    end else begin
      m_clr = bus_we && bus_addr == 4'h0 && bus_wdata[0];
      m_rd  <= f_read(bus_addr, m_en, m_pd, m_cnt, m_ivl);
      m_irq <= f_qual(m_cnt, ring_ne_i, m_en, m_pd, busy_i);
      if (bus_we && bus_addr == 4'h0) m_en <= bus_wdata[1];
      if (m_clr) m_pd <= 0;
      else if (m_en && m_cnt == 0 && ring_ne_i && !busy_i) m_pd <= 1;
      if (bus_we && bus_addr == 4'h4) begin
        m_ivl <= bus_wdata[15:0];
        m_cnt <= bus_wdata[31:16];
      end else if (m_clr) m_cnt <= m_ivl;
      else if (tick_i && m_cnt != 0) m_cnt <= m_cnt - 16'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic tk = 1'b0);
    bus_we = 1; bus_addr = a; bus_wdata = d; tick_i = tk;
    step();
    bus_we = 0; tick_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    step();
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick_i = 1; step(); end
    tick_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    step(); step(); rst = 0; @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 0);
    rd(4'h0, d); chk("R1 ctl", d, 32'h0);
    rd(4'h4, d); chk("R1 mod", d, 32'h00000FA0);

    // R2 reserved bits, R4 write of zero to pending
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, d); chk("R2 reserved/enable", d, 32'h2);
    rd(4'h8, d); chk("R2 unmapped", d, 32'h0);

    // R8 interval write
    wr(4'h4, 32'h0000_0005);
    rd(4'h4, d); chk("R8 interval", d, 32'h0000_0005);

    // R3 pending set, R9 irq
    ring_ne_i = 1;
    step(); step();
    chk("R9 irq on", {31'd0, irq_o}, 1);
    rd(4'h0, d); chk("R3 pending set", d, 32'h3);
    busy_i = 1; step();
    chk("R9 irq drop on busy", {31'd0, irq_o}, 0);
    busy_i = 0;

    // R4 clear beats set, R5 reload
    wr(4'h0, 32'h3);
    rd(4'h0, d); chk("R4 clear wins", d, 32'h2);
    rd(4'h4, d); chk("R5 reload", d, 32'h0005_0005);
    chk("R9 irq low after clear", {31'd0, irq_o}, 0);

    // R6 countdown and hold
    ticks(4);
    rd(4'h4, d); chk("R6 count", d, 32'h0001_0005);
    ticks(4);
    rd(4'h4, d); chk("R6 no wrap", d, 32'h0000_0005);

    // R7 software write beats tick
    wr(4'h4, 32'h0009_0005, 1'b1);
    rd(4'h4, d); chk("R7 write over tick", d, 32'h0009_0005);

    // R10 enable off
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h0000_0005);
    step(); step(); step();
    chk("R10 irq off", {31'd0, irq_o}, 0);
    rd(4'h0, d); chk("R10 no pending", d, 32'h0);
    wr(4'h0, 32'h2); step(); step();
    chk("R9 irq on again", {31'd0, irq_o}, 1);
    wr(4'h0, 32'h0); step();
    chk("R10 irq drops", {31'd0, irq_o}, 0);
    rd(4'h0, d); chk("R10 pending kept", d, 32'h1);

    // seeded random run against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 16;
      bus_we    = (r < 4);
      bus_addr  = (r[0]) ? 4'h4 : ((r % 7 == 0) ? 4'h8 : 4'h0);
      bus_wdata = {$urandom % 10, $urandom % 10};
      bus_wdata[31:16] = 16'($urandom % 10);
      bus_wdata[15:0]  = 16'($urandom % 10);
      bus_wdata[1]     = ($urandom % 4) != 0;
      tick_i    = ($urandom % 3) == 0;
      ring_ne_i = ($urandom % 4) != 0;
      busy_i    = ($urandom % 5) == 0;
      step();
      chk("R9 random irq", {31'd0, irq_o}, {31'd0, m_irq});
      chk("R2/R6 random rdata", bus_rdata, m_rd);
    end
    bus_we = 0; tick_i = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule